// File: doc/BRIEF.md
# Zero-Cross Gated Trigger Pulse Generator

This block turns a digitised zero-cross detector into a single, fixed-width firing pulse for a triac gate. Three asynchronous inputs describe the phase-shifted AC reference: the sign of the differential input, and two flags that say the signal has travelled past the positive or the negative hysteresis threshold. A sign change counts as a crossing worth firing on only when the signal previously swung beyond the threshold on the side it is now leaving. This makes the block immune to chatter around zero.

Each qualified crossing fires one pulse, but only while the separately latched comparison bit is high. A crossing seen with that bit low is still consumed, so it cannot fire later. With the default of 25 ticks at a 1 MHz tick, the pulse lands inside the required 24 to 30 µs window. That is far shorter than the roughly 8.3 ms between crossings of a 60 Hz line. All pins are plain control pins with no handshake: the trigger is a level that the gate driver follows directly.

Top module: `zc_trigger`

## Requirements
- R1: While reset is low the output is 0 and both arm flags are clear. Reset is asynchronous and cuts a pulse that is in progress. After reset, a crossing with no prior threshold excursion fires nothing.
- R2: A falling crossing of the sign input (1 to 0) fires when the above-threshold flag has been seen since the last falling crossing and the enable is 1. The output rises on the third rising clock edge after the sign input changes and stays high for exactly PULSE_TICKS cycles.
- R3: A rising crossing of the sign input (0 to 1) fires under the same rules when the below-threshold flag has been seen since the last rising crossing. It has the same latency and width as R2.
- R4: A crossing whose matching threshold flag has not been seen since the last crossing in that direction produces no pulse. This covers a rising crossing preceded only by an above-threshold excursion.
- R5: A crossing that occurs while the enable input is 0 produces no pulse and still clears its arm flag. A later crossing in the same direction therefore does not fire without a fresh excursion.
- R6: Each threshold excursion allows at most one pulse. After a pulse, further crossings in the same direction stay silent until the flag is seen again.
- R7: A qualified crossing that arrives while a pulse is running neither stretches nor restarts that pulse, and it consumes its arm flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_sign_i | input | 1 | Sign of the differential zero-cross input (1 = positive), asynchronous |
| zc_above_i | input | 1 | Signal is beyond the positive hysteresis threshold, asynchronous |
| zc_below_i | input | 1 | Signal is beyond the negative hysteresis threshold, asynchronous |
| data_i | input | 1 | Latched comparison result that enables firing, synchronous |
| fire_o | output | 1 | Trigger pulse, high for PULSE_TICKS cycles per qualified crossing |

## Verification
The three zero-cross inputs pass through a two-flop synchroniser, and the start of a pulse is registered. A sign change driven between edges therefore shows on the output at the third rising edge. From there the pulse is due for PULSE_TICKS consecutive cycles. A threshold flag needs three edges to arm, so the bench holds each flag and then waits several idle cycles before it moves the sign. After every crossing the bench samples the output on falling edges over a fixed 50-cycle window. It records the index of the first high sample, which must be 3, and the number of high samples, which must equal PULSE_TICKS or be zero. The window is long enough for the longest pulse to finish before the next stimulus.

// File: rtl/zc_pkg.sv
package zc_pkg;

  typedef struct packed {
    logic sign;
    logic above;
    logic below;
  } zc_in_t;

  localparam int ZC_IN_W = $bits(zc_in_t);

endpackage

// File: rtl/zc_sync.sv
module zc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else if (g == 0) begin
          stage_q[g] <= async_i;
        end else begin
          stage_q[g] <= stage_q[(g > 0) ? g-1 : 0];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/zc_arm.sv
module zc_arm
  import zc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  zc_in_t zin,
  output logic   qual_o
);

  logic sign_d;
  logic arm_pos, arm_neg;
  logic rise, fall;

  assign rise = zin.sign & ~sign_d;
  assign fall = ~zin.sign & sign_d;

  // A falling crossing needs a prior positive excursion; a rising one a negative.
  assign qual_o = (rise & arm_neg) | (fall & arm_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_d  <= 1'b0;
      arm_pos <= 1'b0;
      arm_neg <= 1'b0;
    end else begin
      sign_d <= zin.sign;
      if (zin.above)   arm_pos <= 1'b1;
      else if (fall)   arm_pos <= 1'b0;
      if (zin.below)   arm_neg <= 1'b1;
      else if (rise)   arm_neg <= 1'b0;
    end
  end

  assert_fall_consumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !zin.above) |=> !arm_pos);

  assert_rise_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !zin.below) |=> !arm_neg);

  assert_qual_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qual_o |-> (arm_pos || arm_neg));

endmodule

// File: rtl/zc_pulse.sv
module zc_pulse #(
  parameter int PULSE_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  localparam int CW = (PULSE_TICKS > 2) ? $clog2(PULSE_TICKS) : 1;
  localparam int RW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start_i) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end
  end

  assign busy_o = busy;

  // Length of the current high run, used only by the width check.
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_width_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_len != '0) |-> (run_len == RW'(PULSE_TICKS)));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/zc_trigger.sv
module zc_trigger
  import zc_pkg::*;
#(
  parameter int PULSE_TICKS = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_sign_i,
  input  logic zc_above_i,
  input  logic zc_below_i,
  input  logic data_i,
  output logic fire_o
);

  zc_in_t raw, synced;
  logic   qual, start;

  assign raw.sign  = zc_sign_i;
  assign raw.above = zc_above_i;
  assign raw.below = zc_below_i;

  zc_sync #(.WIDTH(ZC_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(synced)
  );

  zc_arm u_arm (
    .clk(clk), .rst_n(rst_n), .zin(synced), .qual_o(qual)
  );

  assign start = qual & data_i;

  zc_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(fire_o)
  );

  assert_fire_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_o) |-> $past(data_i));

  assert_fire_needs_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_o) |-> $past(qual));

endmodule

// File: tb/zc_trigger_test.sv
module zc_trigger_test;

  localparam int W   = 25;
  localparam int WIN = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_sign = 1'b0, zc_above = 1'b0, zc_below = 1'b0, data = 1'b0;
  logic fire;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  zc_trigger #(.PULSE_TICKS(W)) uut (
    .clk(clk), .rst_n(rst_n), .zc_sign_i(zc_sign), .zc_above_i(zc_above),
    .zc_below_i(zc_below), .data_i(data), .fire_o(fire)
  );

  // Vector: {flag[1:0] (0 none, 1 above, 2 below), data, new sign, expect pulse}
  localparam logic [4:0] VEC [10] = '{
    {2'd2, 1'b1, 1'b1, 1'b1},  // R3 rising after below excursion
    {2'd1, 1'b1, 1'b0, 1'b1},  // R2 falling after above excursion
    {2'd0, 1'b1, 1'b1, 1'b0},  // R4 rising with no excursion
    {2'd1, 1'b1, 1'b0, 1'b1},  // R2
    {2'd1, 1'b1, 1'b1, 1'b0},  // R4 rising after only above excursion
    {2'd0, 1'b1, 1'b0, 1'b1},  // R2 arm from previous step still held
    {2'd2, 1'b0, 1'b1, 1'b0},  // R5 enable low
    {2'd0, 1'b1, 1'b0, 1'b0},  // R6 positive arm already used
    {2'd0, 1'b1, 1'b1, 1'b0},  // R5 negative arm consumed while disabled
    {2'd1, 1'b1, 1'b0, 1'b1}   // R2
  };
  localparam string TAG [10] = '{"R3","R2","R4","R2","R4","R2","R5","R6","R5","R2"};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] flg, input logic d, input logic s,
                      input int toggle_at, output int first, output int width);
    @(negedge clk);
    zc_above = (flg == 2'd1);
    zc_below = (flg == 2'd2);
    repeat (2) @(negedge clk);
    zc_above = 1'b0;
    zc_below = 1'b0;
    repeat (5) @(negedge clk);
    data    = d;
    zc_sign = s;
    first = 0;
    width = 0;
    for (int i = 1; i <= WIN; i++) begin
      @(negedge clk);
      if (fire) begin
        if (first == 0) first = i;
        width++;
      end
      if (i == toggle_at) zc_sign = ~zc_sign;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f, w;
    repeat (3) @(negedge clk);
    check(fire == 1'b0, "R1 reset output", fire, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fresh from reset, no excursion, crossing must not fire
    step(2'd0, 1'b1, 1'b1, 0, f, w);
    check(w == 0, "R1 no arm after reset", w, 0);
    step(2'd0, 1'b1, 1'b0, 0, f, w);
    check(w == 0, "R1 no arm after reset", w, 0);

    for (int k = 0; k < 10; k++) begin
      step(VEC[k][4:3], VEC[k][2], VEC[k][1], 0, f, w);
      if (VEC[k][0]) begin
        check(w == W, {TAG[k], " width"}, w, W);
        check(f == 3, {TAG[k], " latency"}, f, 3);
      end else begin
        check(w == 0, {TAG[k], " silent"}, w, 0);
      end
    end

    // R7: both arms set, rising fires, falling crossing mid-pulse ignored
    @(negedge clk);
    zc_above = 1'b1;
    zc_below = 1'b1;
    repeat (2) @(negedge clk);
    step(2'd0, 1'b1, 1'b1, 8, f, w);
    check(w == W, "R7 width unchanged", w, W);
    check(f == 3, "R7 latency", f, 3);
    step(2'd0, 1'b1, 1'b1, 0, f, w);
    check(w == 0, "R7 rising after use", w, 0);
    step(2'd0, 1'b1, 1'b0, 0, f, w);
    check(w == 0, "R7 arm consumed mid-pulse", w, 0);

    // R1: reset cuts a running pulse
    @(negedge clk);
    zc_below = 1'b1;
    repeat (2) @(negedge clk);
    zc_below = 1'b0;
    repeat (5) @(negedge clk);
    zc_sign = 1'b1;
    repeat (6) @(negedge clk);
    check(fire == 1'b1, "R3 pulse running", fire, 1);
    rst_n = 1'b0;
    #1;
    check(fire == 1'b0, "R1 reset cuts pulse", fire, 0);
    @(negedge clk);
    rst_n = 1'b1;
    zc_sign = 1'b0;
    w = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (fire) w++;
    end
    check(w == 0, "R1 arms cleared by reset", w, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule